// File: doc/BRIEF.md
# Byte-Banked Edge/Level Interrupt Aggregator

This block gathers 24 interrupt request lines into a single interrupt output toward a host processor. The lines are grouped into three banks of eight. Each bank has a byte-wide status register and a byte-wide enable register, and both sit on a small 8-bit register bus. Most lines are edge-triggered. A rising edge on an enabled line sets a sticky status bit. Reading the bank's status byte acknowledges those bits. One line, chosen by a parameter, is level-sensitive. Its status bit shows the synchronised input level and is never stored.

The host sees one combined, registered interrupt line. It is high while any enabled status bit is set and drops as soon as nothing enabled is pending. The host detects interrupts on the rising edge of this line, so the drop is needed for the next event to be seen. An edge that arrives while its line is disabled is discarded, not held back for later. Enabling the line afterwards raises nothing for that earlier edge.

Each raw input passes through a two-flop synchroniser. The block detects a rising edge by comparing the synchronised value with its value one clock earlier.

Top module: `irq_byte_agg`

## Requirements
- R1: Source n appears at bit (n mod 8) of bank (n div 8). Status banks sit at addresses 0, 1, 2 and enable banks at 3, 4, 5. `rd_data` presents the addressed byte on the clock edge that samples `rd_en`, then holds that value until the next read.
- R2: After reset, every enable bit and every stored status bit is 0 and `irq_out` is low.
- R3: A write to address 3, 4 or 5 replaces the whole enable byte of that bank and can be read back. An enable bit of 1 enables its source.
- R4: `irq_out` is registered. On each clock edge it takes the OR, over all 24 sources, of status AND enable. If a stored bit's enable is cleared, `irq_out` drops but the bit stays visible in the status byte.
- R5: When an enabled edge source rises, its status bit is set on the third clock edge after the input changes, and `irq_out` rises on the fourth.
- R6: A read of a status byte clears that bank's stored edge bits on the same clock edge and leaves the other banks untouched. `irq_out` then falls one edge later if nothing else is pending.
- R7: A rising edge seen while the source's enable bit is 0 is not stored. Enabling the source later produces no interrupt for that edge.
- R8: When an edge is detected on the same clock edge as a read of its status byte, the bit ends up set. The byte returned by that read does not yet show it.
- R9: The level source (parameter `LEVEL_SRC`, default 10: bank 1, bit 2) reports the synchronised live level. Reads do not clear it, and its status and interrupt fall when the input falls.
- R10: Writes to addresses 0 to 2 and to addresses 6 and above change nothing. Reads of addresses 6 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 24 | Raw interrupt request lines, asynchronous |
| bus_addr | input | 8 | Register address |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bench drives several collisions directly and compares against a behavioural model on every clock:
- **Edge detected on the same edge as a status read.** A design that let the acknowledge win would silently drop that event.
- **Edge while the source is disabled, then the source is enabled.** A design that held the edge pending would fire a stale interrupt.
- **Repeated reads of the level source.** A design that latched or cleared the level bit would either keep `irq_out` stuck high or lose the live level.
- **Clearing an enable while a bit is stored.** A design that cleared status instead of gating it would hide the bit from software.

Random traffic also checks that `irq_out` falls between events, so a host edge detector can see every new event.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    localparam int BANK_W = 8;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_ENABLE = 2'd2
    } acc_kind_t;

    function automatic logic [BANK_W-1:0] bit_sel(input int idx);
        logic [BANK_W-1:0] v;
        v = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (i == idx) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;

endmodule

// File: rtl/irqa_decode.sv
module irqa_decode
    import irqa_pkg::*;
#(
    parameter int NB = 3,
    localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [7:0]        bus_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output acc_kind_t         kind,
    output logic [BIDX_W-1:0] bank,
    output logic [NB-1:0]     rd_stat,
    output logic [NB-1:0]     wr_enab
);
    localparam logic [7:0] STAT_END = 8'(NB);
    localparam logic [7:0] ENAB_END = 8'(2 * NB);

    always_comb begin
        kind = ACC_NONE;
        bank = '0;
        if (bus_addr < STAT_END) begin
            kind = ACC_STATUS;
            bank = BIDX_W'(bus_addr);
        end else if (bus_addr < ENAB_END) begin
            kind = ACC_ENABLE;
            bank = BIDX_W'(bus_addr - STAT_END);
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_strobe
        assign rd_stat[b] = rd_en && (kind == ACC_STATUS) && (bank == BIDX_W'(b));
        assign wr_enab[b] = wr_en && (kind == ACC_ENABLE) && (bank == BIDX_W'(b));
    end

endmodule

// File: rtl/irqa_bank.sv
module irqa_bank
    import irqa_pkg::*;
#(
    parameter int LVL_BIT = -1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] level,
    input  logic [BANK_W-1:0] rise,
    input  logic              rd_clr,
    input  logic              wr_enab,
    input  logic [BANK_W-1:0] wr_data,
    output logic [BANK_W-1:0] enab_q,
    output logic [BANK_W-1:0] edge_q,
    output logic [BANK_W-1:0] hit,
    output logic [BANK_W-1:0] view,
    output logic [BANK_W-1:0] pend
);
    localparam logic [BANK_W-1:0] LVL_MASK = bit_sel(LVL_BIT);

    assign hit = rise & enab_q & ~LVL_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enab_q <= '0;
        end else if (wr_enab) begin
            enab_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= ((rd_clr ? '0 : edge_q) | hit) & ~LVL_MASK;
        end
    end

    assign view = edge_q | (level & LVL_MASK);
    assign pend = view & enab_q;

endmodule

// File: rtl/irq_byte_agg.sv
module irq_byte_agg
    import irqa_pkg::*;
#(
    parameter int NUM_SRC   = 24,
    parameter int LEVEL_SRC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [7:0]         bus_addr,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    output logic               irq_out
);
    localparam int NB     = NUM_SRC / BANK_W;
    localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1;

    logic [NUM_SRC-1:0] lvl_vec;
    logic [NUM_SRC-1:0] rise_vec;
    logic [NUM_SRC-1:0] mask_vec;
    logic [NUM_SRC-1:0] edge_vec;
    logic [NUM_SRC-1:0] hit_vec;
    logic [NUM_SRC-1:0] view_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic               pend_any;

    acc_kind_t          kind;
    logic [BIDX_W-1:0]  bank;
    logic [NB-1:0]      rd_stat;
    logic [NB-1:0]      wr_enab;

    irqa_sync #(.W(NUM_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (src_in),
        .level (lvl_vec),
        .rise  (rise_vec)
    );

    irqa_decode #(.NB(NB)) u_dec (
        .bus_addr (bus_addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .kind     (kind),
        .bank     (bank),
        .rd_stat  (rd_stat),
        .wr_enab  (wr_enab)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int LB = ((LEVEL_SRC / BANK_W) == b) ? (LEVEL_SRC % BANK_W) : -1;
        irqa_bank #(.LVL_BIT(LB)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .level   (lvl_vec[b*BANK_W +: BANK_W]),
            .rise    (rise_vec[b*BANK_W +: BANK_W]),
            .rd_clr  (rd_stat[b]),
            .wr_enab (wr_enab[b]),
            .wr_data (wr_data),
            .enab_q  (mask_vec[b*BANK_W +: BANK_W]),
            .edge_q  (edge_vec[b*BANK_W +: BANK_W]),
            .hit     (hit_vec[b*BANK_W +: BANK_W]),
            .view    (view_vec[b*BANK_W +: BANK_W]),
            .pend    (pend_vec[b*BANK_W +: BANK_W])
        );
    end

    assign pend_any = |pend_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (kind)
                ACC_STATUS: rd_data <= view_vec[int'(bank)*BANK_W +: BANK_W];
                ACC_ENABLE: rd_data <= mask_vec[int'(bank)*BANK_W +: BANK_W];
                default:    rd_data <= '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= pend_any;
        end
    end

endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
    parameter int NUM_SRC = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [7:0]         bus_addr,
    input logic [7:0]         rd_data,
    input logic               irq_out,
    input logic               pend_any,
    input logic [NUM_SRC-1:0] mask_vec,
    input logic [NUM_SRC-1:0] edge_vec,
    input logic [NUM_SRC-1:0] hit_vec
);
    localparam int NB = NUM_SRC / 8;

    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

    assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |=> irq_out);

    assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any |=> !irq_out);

    assert_masked_edge_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_vec & ~$past(edge_vec) & ~$past(mask_vec)) == '0));

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (hit_vec != '0)) |=> ((edge_vec & $past(hit_vec)) == $past(hit_vec)));

    assert_blank_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (bus_addr >= 8'(2 * NB))) |=> (rd_data == 8'h00));

    for (genvar b = 0; b < NB; b++) begin : g_clr
        assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (bus_addr == 8'(b)) && (hit_vec[b*8 +: 8] == 8'h00))
            |=> (edge_vec[b*8 +: 8] == 8'h00));
    end

endmodule

bind irq_byte_agg irqa_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .bus_addr (bus_addr),
    .rd_data  (rd_data),
    .irq_out  (irq_out),
    .pend_any (pend_any),
    .mask_vec (mask_vec),
    .edge_vec (edge_vec),
    .hit_vec  (hit_vec)
);

// File: tb/tb_irq_byte_agg.sv
module tb_irq_byte_agg;

    localparam int LVL = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src = '0;
    logic [7:0]  bus_addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [23:0] m_s1 = '0, m_s2 = '0, m_pv = '0, m_est = '0, m_mk = '0;
    logic        m_irq = 1'b0;
    logic [7:0]  m_rdd = '0;

    always #4 clk = ~clk;

    irq_byte_agg #(.NUM_SRC(24), .LEVEL_SRC(LVL)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src),
        .bus_addr (bus_addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_out  (irq_out)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_step(input bit rd, input bit wr, input logic [7:0] a,
                              input logic [7:0] d, input logic [23:0] s);
        logic [23:0] edg, view, n_est, n_mk;
        edg  = m_s2 & ~m_pv;
        view = m_est;
        view[LVL] = m_s2[LVL];
        n_est = m_est;
        n_mk  = m_mk;
        for (int i = 0; i < 24; i++) begin
            if (i != LVL) begin
                if (edg[i] && m_mk[i]) n_est[i] = 1'b1;
                else if (rd && (int'(a) == i / 8)) n_est[i] = 1'b0;
            end
        end
        if (rd) begin
            if (a < 3)      m_rdd = view[int'(a)*8 +: 8];
            else if (a < 6) m_rdd = m_mk[(int'(a)-3)*8 +: 8];
            else            m_rdd = 8'h00;
        end
        if (wr && a >= 3 && a < 6) n_mk[(int'(a)-3)*8 +: 8] = d;
        m_irq = |(view & m_mk);
        m_est = n_est;
        m_mk  = n_mk;
        m_pv  = m_s2;
        m_s2  = m_s1;
        m_s1  = s;
    endtask

    task automatic tick(input bit rd = 0, input bit wr = 0,
                        input logic [7:0] a = 8'h00, input logic [7:0] d = 8'h00);
        rd_en = rd; wr_en = wr; bus_addr = a; wr_data = d;
        model_step(rd, wr, a, d, src);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R4 model irq_out", {7'd0, irq_out}, {7'd0, m_irq});
        check("R1 model rd_data", rd_data, m_rdd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rd_reg(input logic [7:0] a);
        tick(1, 0, a, 8'h00);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        tick(0, 1, a, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R2 irq low after reset", {7'd0, irq_out}, 8'h00);
        check("R2 rd_data zero after reset", rd_data, 8'h00);
        rd_reg(3); check("R2 enable bank0 reset", rd_data, 8'h00);
        rd_reg(4); check("R2 enable bank1 reset", rd_data, 8'h00);
        rd_reg(5); check("R2 enable bank2 reset", rd_data, 8'h00);

        // R3: enable all and read back
        wr_reg(3, 8'hFF); wr_reg(4, 8'hFF); wr_reg(5, 8'hFF);
        rd_reg(4); check("R3 enable readback", rd_data, 8'hFF);

        // R5: latency of a captured edge
        src[0] = 1'b1;
        idle(3); check("R5 irq not yet", {7'd0, irq_out}, 8'h00);
        tick();  check("R5 irq on fourth edge", {7'd0, irq_out}, 8'h01);
        src[0] = 1'b0;
        idle(2);
        rd_reg(0); check("R1 source 0 at bank0 bit0", rd_data, 8'h01);
        tick();    check("R6 irq falls after read", {7'd0, irq_out}, 8'h00);

        // R1: upper bank mapping
        src[17] = 1'b1; idle(5); src[17] = 1'b0;
        rd_reg(2); check("R1 source 17 at bank2 bit1", rd_data, 8'h02);
        idle(2);

        // R6: reading one bank leaves another pending
        src[1] = 1'b1; src[9] = 1'b1; idle(5); src[1] = 1'b0; src[9] = 1'b0;
        rd_reg(0); check("R6 bank0 byte", rd_data, 8'h02);
        idle(2);   check("R6 bank1 still pending", {7'd0, irq_out}, 8'h01);
        rd_reg(1); check("R6 bank1 byte", rd_data, 8'h02);
        idle(2);   check("R6 irq low after both reads", {7'd0, irq_out}, 8'h00);

        // R4: disabling gates the output, status stays
        src[20] = 1'b1; idle(5); src[20] = 1'b0;
        check("R4 irq set", {7'd0, irq_out}, 8'h01);
        wr_reg(5, 8'h00); idle(1);
        check("R4 irq gated by enable", {7'd0, irq_out}, 8'h00);
        rd_reg(2); check("R4 stored bit still visible", rd_data, 8'h10);
        src[20] = 1'b1; idle(5); src[20] = 1'b0;
        wr_reg(5, 8'hFF); idle(2);
        check("R4 irq after re-enable", {7'd0, irq_out}, 8'h00);
        idle(2);

        // R7: edge while disabled is dropped
        wr_reg(3, 8'h00);
        src[3] = 1'b1; idle(5);
        wr_reg(3, 8'hFF); idle(5);
        check("R7 no irq for masked edge", {7'd0, irq_out}, 8'h00);
        rd_reg(0); check("R7 nothing stored", rd_data, 8'h00);
        src[3] = 1'b0; idle(3);

        // R9: level source
        src[LVL] = 1'b1; idle(4);
        check("R9 level raises irq", {7'd0, irq_out}, 8'h01);
        rd_reg(1); check("R9 level read", rd_data, 8'h04);
        rd_reg(1); check("R9 level survives read", rd_data, 8'h04);
        tick();    check("R9 irq held by level", {7'd0, irq_out}, 8'h01);
        src[LVL] = 1'b0; idle(4);
        check("R9 irq falls with level", {7'd0, irq_out}, 8'h00);
        rd_reg(1); check("R9 level bit clear", rd_data, 8'h00);

        // R8: edge on the same edge as the read
        src[4] = 1'b1; idle(2);
        rd_reg(0); check("R8 read snapshot before edge", rd_data, 8'h00);
        tick();    check("R8 edge kept, irq high", {7'd0, irq_out}, 8'h01);
        rd_reg(0); check("R8 bit set after read", rd_data, 8'h10);
        src[4] = 1'b0; idle(3);

        // R10: ignored writes and blank reads
        wr_reg(0, 8'hFF); wr_reg(6, 8'h00); wr_reg(7, 8'h00);
        rd_reg(0); check("R10 status write ignored", rd_data, 8'h00);
        rd_reg(6); check("R10 blank address reads zero", rd_data, 8'h00);
        rd_reg(3); check("R10 enables untouched", rd_data, 8'hFF);
        check("R10 irq stays low", {7'd0, irq_out}, 8'h00);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) src = src ^ (24'd1 << ($urandom % 24));
            if (r[7:6] == 2'd0)
                tick(1, 0, 8'($urandom % 8), 8'h00);
            else if (r[10:8] == 3'd0)
                tick(0, 1, 8'(3 + $urandom % 5), 8'($urandom));
            else
                tick();
        end

        finish_run();
    end

endmodule